// File: doc/BRIEF.md
# Push-Button Volume Stepper

This block turns two active-low push buttons into a 5-bit gain index with 32 positions. Index 31 is the loudest setting (+24 dB) and index 0 the quietest (-80 dB). The block divides a fast oscillator clock down to a slow control tick and samples the buttons only on that tick. A short press moves the index by one position. If the button stays down, the index pauses, then repeats at a steady faster rate until the button is let go.

An active-low shutdown input turns the amplifier off and freezes the index. The index keeps its value through shutdown, so the same volume comes back when shutdown is released. All three pins pass through a two-stage synchroniser in the oscillator domain. Translating the index into a gain and driving the analog stages are left to the logic that consumes `gain_idx`.

Top module: `vol_stepper`

## Requirements
- R1: The control tick occurs once every 2^TICK_LOG2 oscillator cycles (default 8192). All repeat timing is counted in ticks.
- R2: `up_n` and `down_n` request a step only while they are low. When both are high, the index does not change.
- R3: A press that has been seen low on 1 tick moves the index one position in the direction of that button (up = +1, down = -1).
- R4: If the same button is still held, the second step comes 10 ticks after the first.
- R5: While that button stays held, every later step comes 4 ticks after the previous one.
- R6: The index saturates at 0 and at 31 and never wraps. A request past either end has no effect.
- R7: Reset loads index 26, which is the +12 dB position when 31 stands for +24 dB.
- R8: While `sd_n` is low, `amp_active` is low (after the two-cycle synchroniser), no step occurs and the index is kept. Releasing `sd_n` brings the same index back.
- R9: If both buttons are low on a tick, no step occurs and the hold schedule returns to idle.
- R10: Releasing the button restarts the schedule, so the next press again steps after 1 tick. Switching directly to the other button does the same.
- R11: The index changes by exactly one position per step, and only in the cycle after a step pulse. A step pulse follows a tick by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| up_n | input | 1 | Volume-up button, active low, asynchronous |
| down_n | input | 1 | Volume-down button, active low, asynchronous |
| sd_n | input | 1 | Shutdown, active low, asynchronous |
| gain_idx | output | 5 | Gain position, 0 = -80 dB, 31 = +24 dB |
| amp_active | output | 1 | High while the amplifier is enabled (synchronised `sd_n`) |

## Verification
The assertions check on every cycle the following:
- The index moves by a single position and never wraps at either end.
- Every index change is caused by a step pulse that came one cycle after a tick.
- Ticks taken during shutdown, or with both buttons down, produce no step.

The bench scenarios are the only way to show the things that span many ticks:
- the 1/10/4 tick schedule, measured in oscillator cycles;
- restarting the schedule after a release or a change of direction;
- keeping the index through shutdown;
- the reset value.

// File: rtl/vol_pkg.sv
package vol_pkg;

    localparam int unsigned IDX_W        = 5;
    localparam int unsigned IDX_DEFAULT  = 26;
    localparam int unsigned HOLD_FIRST   = 1;
    localparam int unsigned HOLD_GAP     = 10;
    localparam int unsigned HOLD_REPEAT  = 4;
    localparam int unsigned TICK_LOG2    = 13;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_FIRST,
        PH_GAP,
        PH_REPEAT
    } hold_phase_e;

    typedef struct packed {
        logic sd_on;
        logic press_dn;
        logic press_up;
    } ctl_s;

    function automatic hold_phase_e phase_after(input hold_phase_e p);
        return (p == PH_FIRST) ? PH_GAP : PH_REPEAT;
    endfunction

    function automatic int unsigned phase_limit(input hold_phase_e p,
                                                input int unsigned first,
                                                input int unsigned gap,
                                                input int unsigned rep);
        case (p)
            PH_GAP:    return gap;
            PH_REPEAT: return rep;
            default:   return first;
        endcase
    endfunction

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/vol_tick_div.sv
module vol_tick_div #(
    parameter int unsigned LOG2 = 13
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    logic [LOG2-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + 1'b1;
    end

    assign tick = &cnt_q;
endmodule

// File: rtl/vol_sync.sv
module vol_sync #(
    parameter int unsigned   W       = 3,
    parameter int unsigned   STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/vol_hold_fsm.sv
module vol_hold_fsm
    import vol_pkg::*;
#(
    parameter int unsigned FIRST  = HOLD_FIRST,
    parameter int unsigned GAP    = HOLD_GAP,
    parameter int unsigned REPEAT = HOLD_REPEAT
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  ctl_s ctl,
    output logic step_up,
    output logic step_dn
);
    localparam int unsigned CNT_W = $clog2(max3(FIRST, GAP, REPEAT) + 1);

    hold_phase_e      phase_q, eff_phase;
    logic [CNT_W-1:0] cnt_q, base, nxt;
    logic             held_up_q;
    logic             new_press, hit, valid_press;

    assign valid_press = ctl.sd_on && (ctl.press_up != ctl.press_dn);

    always_comb begin
        new_press = (phase_q == PH_IDLE) || (held_up_q != ctl.press_up);
        eff_phase = new_press ? PH_FIRST : phase_q;
        base      = new_press ? '0 : cnt_q;
        nxt       = base + 1'b1;
        hit       = (nxt == CNT_W'(phase_limit(eff_phase, FIRST, GAP, REPEAT)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            held_up_q <= 1'b0;
            step_up   <= 1'b0;
            step_dn   <= 1'b0;
        end else begin
            step_up <= 1'b0;
            step_dn <= 1'b0;
            if (tick) begin
                if (!valid_press) begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end else begin
                    held_up_q <= ctl.press_up;
                    if (hit) begin
                        step_up <= ctl.press_up;
                        step_dn <= ctl.press_dn;
                        phase_q <= phase_after(eff_phase);
                        cnt_q   <= '0;
                    end else begin
                        phase_q <= eff_phase;
                        cnt_q   <= nxt;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/vol_index_reg.sv
module vol_index_reg #(
    parameter int unsigned W       = 5,
    parameter int unsigned DEFAULT = 26
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] idx
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst)                           idx <= W'(DEFAULT);
        else if (step_up && idx != TOP)    idx <= idx + 1'b1;
        else if (step_dn && idx != '0)     idx <= idx - 1'b1;
    end
endmodule

// File: rtl/vol_stepper.sv
module vol_stepper
    import vol_pkg::*;
#(
    parameter int unsigned TICK_BITS = TICK_LOG2,
    parameter int unsigned W         = IDX_W,
    parameter int unsigned DEF_IDX   = IDX_DEFAULT,
    parameter int unsigned T_FIRST   = HOLD_FIRST,
    parameter int unsigned T_GAP     = HOLD_GAP,
    parameter int unsigned T_REPEAT  = HOLD_REPEAT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         up_n,
    input  logic         down_n,
    input  logic         sd_n,
    output logic [W-1:0] gain_idx,
    output logic         amp_active
);
    logic       tick;
    logic [2:0] pins_s;
    ctl_s       ctl;
    logic       step_up, step_dn;

    vol_tick_div #(.LOG2(TICK_BITS)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    vol_sync #(.W(3), .STAGES(2), .RST_VAL(3'b011)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({sd_n, down_n, up_n}),
        .dout (pins_s)
    );

    assign ctl.sd_on    = pins_s[2];
    assign ctl.press_dn = ~pins_s[1];
    assign ctl.press_up = ~pins_s[0];

    vol_hold_fsm #(.FIRST(T_FIRST), .GAP(T_GAP), .REPEAT(T_REPEAT)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ctl     (ctl),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    vol_index_reg #(.W(W), .DEFAULT(DEF_IDX)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .step_up (step_up),
        .step_dn (step_dn),
        .idx     (gain_idx)
    );

    assign amp_active = ctl.sd_on;
endmodule

// File: rtl/vol_stepper_chk.sv
module vol_stepper_chk #(
    parameter int unsigned W = 5
) (
    input logic         clk,
    input logic         rst,
    input logic         tick,
    input logic         press_up,
    input logic         press_dn,
    input logic         sd_on,
    input logic         step_up,
    input logic         step_dn,
    input logic [W-1:0] gain_idx
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // R11
    idx_one_step_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_idx != $past(gain_idx)) |->
            ((gain_idx == $past(gain_idx) + 1'b1) || (gain_idx == $past(gain_idx) - 1'b1)));

    // R6
    no_wrap_top_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(gain_idx) == TOP) |-> (gain_idx != '0));

    // R6
    no_wrap_bot_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(gain_idx) == '0) |-> (gain_idx != TOP));

    // R11
    step_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (step_up || step_dn) |-> $past(tick));

    // R11
    idx_needs_step_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_idx != $past(gain_idx)) |-> $past(step_up || step_dn));

    // R9
    both_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && press_up && press_dn) |=> !(step_up || step_dn));

    // R8
    sd_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !sd_on) |=> !(step_up || step_dn));

    // R2
    up_needs_press_chk: assert property (@(posedge clk) disable iff (rst)
        step_up |-> $past(press_up));
endmodule

bind vol_stepper vol_stepper_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .press_up (ctl.press_up),
    .press_dn (ctl.press_dn),
    .sd_on    (ctl.sd_on),
    .step_up  (step_up),
    .step_dn  (step_dn),
    .gain_idx (gain_idx)
);

// File: tb/sim_vol_stepper.sv
module sim_vol_stepper;
    localparam int K  = 4;
    localparam int P  = 1 << K;
    localparam int WD = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_n = 1'b1, down_n = 1'b1, sd_n = 1'b1;
    logic [4:0] gain_idx;
    logic amp_active;

    int checks = 0;
    int errors = 0;
    int exp_idx;

    always #2.5 clk = ~clk;

    vol_stepper #(.TICK_BITS(K)) u0 (
        .clk(clk), .rst(rst), .up_n(up_n), .down_n(down_n), .sd_n(sd_n),
        .gain_idx(gain_idx), .amp_active(amp_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // steps produced by a hold of n ticks: 1 at tick 1, 1 at tick 11, then every 4
    function automatic int nsteps(input int n);
        if (n < 1) return 0;
        if (n < 11) return 1;
        return 2 + (n - 11) / 4;
    endfunction

    function automatic int apply(input int idx, input int dir, input int n);
        int v;
        v = idx + dir * nsteps(n);
        if (v > 31) v = 31;
        if (v < 0) v = 0;
        return v;
    endfunction

    task automatic seg(input logic u, input logic d, input logic s, input int n);
        up_n = u; down_n = d; sd_n = s;
        repeat (n * P) @(negedge clk);
    endtask

    task automatic release_tick();
        seg(1'b1, 1'b1, 1'b1, 1);
    endtask

    task automatic run();
        int ch [8];
        int nch;
        int prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R7 reset value
        chk("R7 reset index", gain_idx, 26);
        repeat (P / 2) @(negedge clk);
        chk("R8 amp_active after reset", amp_active, 1);
        exp_idx = 26;

        // R6 saturate at top
        seg(1'b0, 1'b1, 1'b1, 40); release_tick();
        exp_idx = apply(exp_idx, 1, 40);
        chk("R6 top saturation", gain_idx, exp_idx);

        // R3 single tick press
        seg(1'b1, 1'b0, 1'b1, 1); release_tick();
        exp_idx = apply(exp_idx, -1, 1);
        chk("R3 single step down", gain_idx, exp_idx);

        // R9 both pressed
        seg(1'b0, 1'b0, 1'b1, 12); release_tick();
        chk("R9 both pressed no step", gain_idx, exp_idx);

        // R2 both high
        seg(1'b1, 1'b1, 1'b1, 5);
        chk("R2 idle no change", gain_idx, exp_idx);

        // R6 saturate at bottom
        seg(1'b1, 1'b0, 1'b1, 60); release_tick();
        exp_idx = apply(exp_idx, -1, 60);
        chk("R6 bottom saturation", gain_idx, exp_idx);

        // R1 R3 R4 R5 timing measured in oscillator cycles
        nch = 0;
        prev = gain_idx;
        up_n = 1'b0;
        for (int k = 0; k < 20 * P; k++) begin
            @(negedge clk);
            if (gain_idx != prev) begin
                if (nch < 8) ch[nch] = k;
                nch++;
                prev = gain_idx;
            end
        end
        release_tick();
        exp_idx = apply(exp_idx, 1, 20);
        chk("R5 step count over 20 ticks", nch, 4);
        chk("R3 first step within one tick", (nch > 0 && ch[0] <= P) ? 1 : 0, 1);
        if (nch >= 4) begin
            chk("R4 R1 gap to second step", ch[1] - ch[0], 10 * P);
            chk("R5 repeat interval a", ch[2] - ch[1], 4 * P);
            chk("R5 repeat interval b", ch[3] - ch[2], 4 * P);
        end
        chk("R11 index after timing run", gain_idx, exp_idx);

        // R8 shutdown keeps index, ignores presses
        seg(1'b0, 1'b1, 1'b0, 15);
        chk("R8 amp_active low in shutdown", amp_active, 0);
        chk("R8 index held in shutdown", gain_idx, exp_idx);
        release_tick();
        chk("R8 index restored", gain_idx, exp_idx);
        chk("R8 amp_active restored", amp_active, 1);

        // R10 direction switch restarts schedule
        seg(1'b0, 1'b1, 1'b1, 3);
        seg(1'b1, 1'b0, 1'b1, 2);
        release_tick();
        exp_idx = apply(apply(exp_idx, 1, 3), -1, 2);
        chk("R10 direction switch", gain_idx, exp_idx);

        // R10 release restarts: two short presses give two steps
        seg(1'b0, 1'b1, 1'b1, 2); release_tick();
        seg(1'b0, 1'b1, 1'b1, 2); release_tick();
        exp_idx = apply(apply(exp_idx, 1, 2), 1, 2);
        chk("R10 re-press steps again", gain_idx, exp_idx);

        // random mix
        void'($urandom(32'd4711));
        for (int i = 0; i < 40; i++) begin
            int kind, n;
            kind = int'($urandom % 4);
            n = 1 + int'($urandom % 22);
            case (kind)
                0: begin seg(1'b0, 1'b1, 1'b1, n); exp_idx = apply(exp_idx, 1, n); end
                1: begin seg(1'b1, 1'b0, 1'b1, n); exp_idx = apply(exp_idx, -1, n); end
                2: seg(1'b0, 1'b0, 1'b1, n);
                default: begin
                    seg(1'b1, 1'b0, 1'b0, n);
                    chk("R8 random shutdown amp", amp_active, 0);
                end
            endcase
            release_tick();
            chk("R5 R6 R9 random segment", gain_idx, exp_idx);
        end
    endtask

    initial begin
        fork
            run();
            begin
                repeat (WD) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", WD, 0);
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule